// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block is the transmit side of a slave audio serial port. An external master supplies the bit clock and the frame sync. Once per frame the block captures four parallel PCM samples and shifts them out, most significant bit first, on one shared data line. Three framings are available: a multi-slot TDM frame, I2S, and left-justified. The word length is programmable. Each channel can be placed in any of 64 slots. The start of the slots can be delayed by up to 31 bit clocks, and either incoming clock can be inverted.

The data line comes with an output-enable. The enable is high only while the block drives a bit that belongs to one of its own channels, so several transmitters can share one line, each using different slots. Both incoming clocks are oversampled by the system clock `clk`. All internal state changes on `clk` edges that follow a detected transmit edge of the bit clock.

The sequencer is a four-state machine:

- **IDLE** is the state after reset. It moves to LEAD or SHIFT on a frame start.
- **LEAD** counts the delay bits before slot 0. It moves to SHIFT when the count reaches the delay.
- **SHIFT** sends the slots one after another. It moves to TAIL after the bit at the end of the last slot.
- **TAIL** stays silent until the next start.

A frame start, or a right-half start in I2S or left-justified mode, restarts the machine from any state except that a right-half start is ignored in IDLE.

Top module: `aspt_tx`

## Requirements
- R1: With `cfg_fmt`=00 (TDM), a frame starts at the rising edge of the effective frame sync. The frame has one half of 64 slots, and slot code n is slot n. The first data bit goes out on the transmit edge at which the new sync level is seen.
- R2: With `cfg_fmt`=01 (I2S), the left half starts at the falling edge of the effective frame sync and the right half starts at its rising edge. The first data bit of each half goes out one bit clock after the edge.
- R3: With `cfg_fmt`=10 (left-justified), the left half starts at the rising edge and the right half at the falling edge of the effective frame sync. The first data bit goes out on the same transmit edge as the sync change.
- R4: `cfg_wlen` codes 00, 01, 10 and 11 give word lengths L of 16, 20, 24 and 32 bits. Every slot is L bits wide and carries bits 31 down to 32−L of the channel's 32-bit sample, most significant bit first.
- R5: Each channel has a 6-bit slot code held in `ch_slots[6n+5:6n]` for channel n. In I2S and left-justified modes, codes 0 to 31 are left-half slots 0 to 31 and codes 32 to 63 are right-half slots 0 to 31. Each half holds 32 slots.
- R6: `cfg_offset` (0 to 31) delays the first slot of every half by that many bit clocks, in addition to the format's own delay.
- R7: `cfg_fsync_inv`=1 inverts the frame sync before it is interpreted.
- R8: `cfg_bclk_inv`=1 inverts the bit clock. Data changes only on transmit edges, which are the falling edges of the effective bit clock. A receiver samples the data on the rising edges.
- R9: `sd_oe` is low during the delay bits, in slots that no channel claims, after the last slot of a half, and before the first frame. `sdout` is 0 whenever `sd_oe` is low.
- R10: The samples are captured on the frame start. Changing `ch_samples` later in the frame does not change what is sent in either half.
- R11: When two channels claim the same slot, the lower-numbered channel supplies the data.
- R12: After reset, `sd_oe` and `sdout` are low and stay low until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the bus master |
| fsync | input | 1 | Frame sync from the bus master |
| cfg_fmt | input | 2 | Framing: 00 TDM, 01 I2S, 10 left-justified, 11 reserved |
| cfg_wlen | input | 2 | Word length code |
| cfg_offset | input | 5 | Extra delay of the first slot, in bit clocks |
| cfg_fsync_inv | input | 1 | Invert frame sync polarity |
| cfg_bclk_inv | input | 1 | Invert bit clock polarity |
| ch_samples | input | 128 | Four 32-bit samples; channel n at bits [32n+31:32n] |
| ch_slots | input | 24 | Four 6-bit slot codes; channel n at bits [6n+5:6n] |
| sdout | output | 1 | Serial data |
| sd_oe | output | 1 | Drive enable for the shared data line |

## Verification
A bit-clock edge is first registered in `clk`. The detected transmit edge then updates the sequencer on the next `clk` edge. As a result, `sdout` and `sd_oe` settle two `clk` edges after the bit clock falls, and a frame start latches the samples on that same edge. The bench holds each bit-clock phase for three `clk` cycles and compares the outputs just before it raises the bit clock, which is well after they have settled and before the next transmit edge. The expected value of every bit is worked out arithmetically from the bit position, format, delay, word length, slot map and the samples given at the frame start.

// File: rtl/aspt_pkg.sv
package aspt_pkg;
    localparam int SAMPLE_W = 32;
    localparam int BIT_W    = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        FMT_TDM  = 2'b00,
        FMT_I2S  = 2'b01,
        FMT_LJ   = 2'b10,
        FMT_RSVD = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } st_e;

    // word length in bits for a 2-bit code
    function automatic logic [BIT_W:0] wlen_bits(input logic [1:0] code);
        logic [BIT_W:0] w;
        unique case (code)
            2'b00:   w = (BIT_W+1)'(16);
            2'b01:   w = (BIT_W+1)'(20);
            2'b10:   w = (BIT_W+1)'(24);
            default: w = (BIT_W+1)'(32);
        endcase
        return w;
    endfunction
endpackage

// File: rtl/aspt_edge_sync.sv
module aspt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic bclk_inv,
    input  logic fsync_inv,
    output logic tick,
    output logic fs_now
);
    logic bq, bq2, fq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bq  <= 1'b0;
            bq2 <= 1'b0;
            fq  <= 1'b0;
        end else begin
            bq  <= bclk ^ bclk_inv;
            bq2 <= bq;
            fq  <= fsync ^ fsync_inv;
        end
    end

    // transmit edge: falling edge of the effective bit clock
    assign tick   = bq2 & ~bq;
    assign fs_now = fq;
endmodule

// File: rtl/aspt_seq.sv
module aspt_seq
    import aspt_pkg::*;
#(
    parameter int SLOT_W = 6,
    parameter int OFFS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fs_now,
    input  logic [1:0]        fmt,
    input  logic [1:0]        wlen_code,
    input  logic [OFFS_W-1:0] offset,
    output st_e               st,
    output logic              frame_start,
    output logic              active,
    output logic [SLOT_W-1:0] slot_code,
    output logic [BIT_W-1:0]  bit_idx
);
    localparam int LEAD_W = OFFS_W + 1;
    localparam logic [SLOT_W-1:0] FULL_LAST = '1;
    localparam logic [SLOT_W-1:0] HALF_LAST = {1'b0, {(SLOT_W-1){1'b1}}};

    st_e               st_n;
    logic              fs_prev, half, half_n;
    logic [LEAD_W-1:0] cnt, cnt_n, cnt_inc, lead;
    logic [SLOT_W-1:0] slot, slot_n, slot_inc, last_slot;
    logic [BIT_W-1:0]  bit_n;
    logic [BIT_W:0]    bit_inc, wl;
    logic              is_i2s, split, rise, fall, start_right;

    assign is_i2s    = (fmt == FMT_I2S);
    assign split     = is_i2s || (fmt == FMT_LJ);
    assign rise      = fs_now & ~fs_prev;
    assign fall      = ~fs_now & fs_prev;
    assign frame_start = tick && (is_i2s ? fall : rise);
    assign start_right = tick && split && (st != ST_IDLE) && (is_i2s ? rise : fall);
    assign lead      = {1'b0, offset} + {{(LEAD_W-1){1'b0}}, is_i2s};
    assign last_slot = split ? HALF_LAST : FULL_LAST;
    assign wl        = wlen_bits(wlen_code);
    assign cnt_inc   = cnt + {{(LEAD_W-1){1'b0}}, 1'b1};
    assign slot_inc  = slot + {{(SLOT_W-1){1'b0}}, 1'b1};
    assign bit_inc   = {1'b0, bit_idx} + {{BIT_W{1'b0}}, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            fs_prev <= 1'b0;
            half    <= 1'b0;
            cnt     <= '0;
            slot    <= '0;
            bit_idx <= '0;
        end else begin
            st      <= st_n;
            if (tick) fs_prev <= fs_now;
            half    <= half_n;
            cnt     <= cnt_n;
            slot    <= slot_n;
            bit_idx <= bit_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        half_n = half;
        cnt_n  = cnt;
        slot_n = slot;
        bit_n  = bit_idx;
        if (frame_start || start_right) begin
            half_n = start_right;
            cnt_n  = '0;
            slot_n = '0;
            bit_n  = '0;
            st_n   = (lead == '0) ? ST_SHIFT : ST_LEAD;
        end else if (tick) begin
            unique case (st)
                ST_IDLE: ;
                ST_LEAD: begin
                    if (cnt_inc >= lead) st_n = ST_SHIFT;
                    else                 cnt_n = cnt_inc;
                end
                ST_SHIFT: begin
                    if (bit_inc >= wl) begin
                        bit_n = '0;
                        if (slot >= last_slot) st_n = ST_TAIL;
                        else                   slot_n = slot_inc;
                    end else begin
                        bit_n = bit_inc[BIT_W-1:0];
                    end
                end
                ST_TAIL: ;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        active    = (st == ST_SHIFT);
        slot_code = split ? {half, slot[SLOT_W-2:0]} : slot;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st)); // R8
    AST_START_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st != ST_IDLE)); // R1
endmodule

// File: rtl/aspt_chmap.sv
module aspt_chmap
    import aspt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [NUM_CH*SLOT_W-1:0]   slot_cfg,
    input  logic                       active,
    input  logic [SLOT_W-1:0]          slot_code,
    input  logic [BIT_W-1:0]           bit_idx,
    output logic                       sd,
    output logic                       oe
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(SAMPLE_W - 1);

    logic [NUM_CH-1:0][SAMPLE_W-1:0] lat;
    logic [NUM_CH-1:0]               hit;
    logic [CH_W-1:0]                 sel;
    logic                            any;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           lat[g] <= '0;
            else if (frame_start) lat[g] <= samples[g*SAMPLE_W +: SAMPLE_W];
        end
        assign hit[g] = (slot_cfg[g*SLOT_W +: SLOT_W] == slot_code);
    end

    // lowest channel number wins
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel = i[CH_W-1:0];
                any = 1'b1;
            end
        end
    end

    always_comb begin
        oe = active && any;
        sd = oe ? lat[sel][MSB_IDX - bit_idx] : 1'b0;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(lat)); // R10
endmodule

// File: rtl/aspt_tx.sv
module aspt_tx
    import aspt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 6,
    parameter int OFFS_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bclk,
    input  logic                       fsync,
    input  logic [1:0]                 cfg_fmt,
    input  logic [1:0]                 cfg_wlen,
    input  logic [OFFS_W-1:0]          cfg_offset,
    input  logic                       cfg_fsync_inv,
    input  logic                       cfg_bclk_inv,
    input  logic [NUM_CH*SAMPLE_W-1:0] ch_samples,
    input  logic [NUM_CH*SLOT_W-1:0]   ch_slots,
    output logic                       sdout,
    output logic                       sd_oe
);
    logic              tick, fs_now, frame_start, active;
    logic [SLOT_W-1:0] slot_code;
    logic [BIT_W-1:0]  bit_idx;
    st_e               st;

    aspt_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .bclk_inv(cfg_bclk_inv), .fsync_inv(cfg_fsync_inv),
        .tick(tick), .fs_now(fs_now)
    );

    aspt_seq #(.SLOT_W(SLOT_W), .OFFS_W(OFFS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fs_now(fs_now),
        .fmt(cfg_fmt), .wlen_code(cfg_wlen), .offset(cfg_offset),
        .st(st), .frame_start(frame_start), .active(active),
        .slot_code(slot_code), .bit_idx(bit_idx)
    );

    aspt_chmap #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_map (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .samples(ch_samples), .slot_cfg(ch_slots), .active(active),
        .slot_code(slot_code), .bit_idx(bit_idx), .sd(sdout), .oe(sd_oe)
    );

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sd_oe); // R12
    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sdout); // R9
    AST_OE_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (st == ST_SHIFT)); // R9
endmodule

// File: tb/tb_aspt_tx.sv
module tb_aspt_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HB = 3;
    localparam int FB = 128;

    logic         clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0;
    logic [1:0]   cfg_fmt = 2'b00, cfg_wlen = 2'b11;
    logic [4:0]   cfg_offset = '0;
    logic         fs_inv = 1'b0, bc_inv = 1'b0;
    logic [127:0] smp = '0;
    logic [23:0]  slots = '0;
    logic         sdout, sd_oe;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] fv [4];
    int cs [4];

    aspt_tx dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_offset(cfg_offset),
        .cfg_fsync_inv(fs_inv), .cfg_bclk_inv(bc_inv),
        .ch_samples(smp), .ch_slots(slots), .sdout(sdout), .sd_oe(sd_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected {oe, sd} for bit position p of a half
    function automatic logic [1:0] model(int fmt, int wl, int off, int half, int p);
        int d, s, b, code, nsl;
        d = p - off - ((fmt == 1) ? 1 : 0);
        if (d < 0) return 2'b00;
        s = d / wl;
        b = d % wl;
        nsl = (fmt == 0) ? 64 : 32;
        if (s >= nsl) return 2'b00;
        code = (fmt == 0) ? s : half * 32 + s;
        for (int c = 0; c < 4; c++)
            if (cs[c] == code) return {1'b1, fv[c][31 - b]};
        return 2'b00;
    endfunction

    task automatic compare(logic [1:0] exp, string tag);
        checks++;
        if ({sd_oe, sdout} !== exp) begin
            fails++;
            $display("FAIL %s: got oe=%b sd=%b expected oe=%b sd=%b (t=%0t)",
                     tag, sd_oe, sdout, exp[1], exp[0], $time);
        end
    endtask

    // one bit-clock period: transmit edge, settle, optional compare, sample edge
    task automatic bit_cycle(bit fs_eff, bit do_chk, logic [1:0] exp, string tag);
        @(negedge clk);
        bclk  = bc_inv;
        fsync = fs_eff ^ fs_inv;
        repeat (HB) @(negedge clk);
        if (do_chk) compare(exp, tag);
        bclk = ~bc_inv;
        repeat (HB - 1) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int ci;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        compare(2'b00, "R12 reset state");
        // no frame start yet: must stay silent
        for (int k = 0; k < 4; k++) bit_cycle(1'b0, 1'b1, 2'b00, "R12 idle before first frame");

        ci = 0;
        for (int fmt = 0; fmt < 3; fmt++) begin
            for (int wc = 0; wc < 4; wc++) begin
                for (int oi = 0; oi < 4; oi++) begin
                    int off, wl, pol;
                    string tag;
                    bit idle_fs;
                    off = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 7 : 31;
                    wl  = (wc == 3) ? 32 : 16 + 4 * wc;
                    pol = (ci * 5 + fmt) % 4;
                    cfg_fmt    = fmt[1:0];
                    cfg_wlen   = wc[1:0];
                    cfg_offset = off[4:0];
                    bc_inv     = pol[0];
                    fs_inv     = pol[1];
                    // R11: channel 3 duplicates channel 0 in set A
                    if (ci % 2 == 0) begin cs[0] = 0;  cs[1] = 32; cs[2] = 1; cs[3] = 0; end
                    else             begin cs[0] = 33; cs[1] = 1;  cs[2] = 0; cs[3] = 2; end
                    for (int c = 0; c < 4; c++) slots[c*6 +: 6] = cs[c][5:0];
                    tag = (fmt == 0) ? "R1" : (fmt == 1) ? "R2" : "R3";
                    tag = {tag, " R4 R5 R6 R7 R8 R9 R10 R11"};
                    idle_fs = (fmt == 1);
                    for (int k = 0; k < 3; k++) bit_cycle(idle_fs, 1'b0, 2'b00, "");
                    for (int f = 0; f < 2; f++) begin
                        for (int c = 0; c < 4; c++) fv[c] = $urandom();
                        for (int k = 0; k < FB; k++) begin
                            bit fs;
                            int half, p;
                            if (k == 0) for (int c = 0; c < 4; c++) smp[c*32 +: 32] = fv[c];
                            if (k == 5) smp = ~smp; // R10: late change must be ignored
                            fs   = (fmt == 0) ? (k == 0) : (fmt == 1) ? (k >= FB/2) : (k < FB/2);
                            half = (fmt != 0 && k >= FB/2) ? 1 : 0;
                            p    = half ? k - FB/2 : k;
                            bit_cycle(fs, 1'b1, model(fmt, wl, off, half, p), tag);
                        end
                    end
                    ci++;
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule